// File: doc/BRIEF.md
# Sign/Logarithm Arithmetic Unit

This block is a pipelined arithmetic unit for real numbers held in sign/logarithm form. Each value is a sign bit with a two's-complement base-2 logarithm of its magnitude. The logarithm has 6 integer bits and 9 fractional bits. Zero cannot be written as a logarithm, so it travels on a separate flag beside each operand and beside the result.

A 3-bit code selects the operation. Multiply, divide, square, cube and reciprocal need no multiplier, because each reduces to integer add, subtract, shift or negate on the log field. Add and subtract keep the larger logarithm and add a correction to it. The correction is read from one of two small tables indexed by the quantised log difference. Both tables are filled at elaboration from their defining functions.

Operands and the code are offered with a valid/ready pair. The result, its zero flag and an overflow flag appear registered two clock edges after acceptance. A new operation can be accepted on every cycle.

Top module: `lns_arith_unit`

## Requirements
- R1: An operand or result word has the sign in bit 15 (0 positive, 1 negative) and the two's-complement log field in bits 14:0, scaled by 512. A set zero flag means the value is zero. A zero result always drives the word as 0 and the overflow flag low.
- R2: Code 0 multiplies: the result log is the sum of the operand logs, and the sign is the XOR of the operand signs. If either operand is zero, the result is zero.
- R3: Code 1 divides A by B: the result log is log A minus log B, and the sign is the XOR of the signs. A zero divisor gives overflow, log 16383 and the XOR sign. Otherwise, a zero dividend gives zero.
- R4: Code 2 squares A: the log is doubled and the sign is 0. Code 3 cubes A: the log is tripled and the sign is A's sign. A zero A gives zero for both.
- R5: Code 4 takes the reciprocal of A: the log is negated and the sign is kept. A zero A gives overflow, log 16383 and A's sign.
- R6: Codes 5 (A+B) and 6 (A-B) use an effective B sign equal to B's sign XOR (code==6). Let z = |logA - logB|. The result log is the larger log plus the correction. The correction comes from the sum table when the signs agree and from the difference table when they differ. The result sign is the sign of the larger operand; A counts as larger when the logs are equal.
- R7: The table index is z>>5, a step of 1/16. The entry is round(512*log2(1 ± 2^-((index+0.5)/16))), rounded half away from zero. Indexes of 256 and above (z of 16.0 or more) give a correction of 0, so the result equals the larger operand.
- R8: An add or subtract whose effective signs differ and whose logs are equal gives zero.
- R9: For add and subtract, a zero A returns B with its effective sign, and a zero B returns A. Two zero operands give zero.
- R10: A result log above 16383 or below -16384 clamps to that bound and raises overflow.
- R11: in_ready is low during reset and high from the first edge after reset is released. An input accepted at one edge yields out_valid for exactly one cycle after the second edge, and inputs may be accepted on every cycle.
- R12: Code 7 copies A. A zero A gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and code are offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 3 | Operation code |
| in_a_zero | input | 1 | Operand A is zero |
| in_a | input | 16 | Operand A, sign and log |
| in_b_zero | input | 1 | Operand B is zero |
| in_b | input | 16 | Operand B, sign and log |
| out_valid | output | 1 | Result is present this cycle |
| out_zero | output | 1 | Result is zero |
| out_ovf | output | 1 | Result log was clamped |
| out_val | output | 16 | Result, sign and log |

## Verification
The assertions assume that rst_n is held low for at least two clock edges. During that time in_ready stays low, so nothing is accepted and the two-edge latency history starts clean. The bench holds reset for several cycles and changes inputs only on falling edges. It drives the operand words as full 16-bit patterns even when their zero flags are set. The saturation check also assumes that out_val is meaningful only while out_valid is high, so the stimulus samples results only in those cycles.

// File: rtl/lns_pkg.sv
package lns_pkg;

  typedef enum logic [2:0] {
    LNS_MUL   = 3'd0,
    LNS_DIV   = 3'd1,
    LNS_SQR   = 3'd2,
    LNS_CUBE  = 3'd3,
    LNS_RECIP = 3'd4,
    LNS_ADD   = 3'd5,
    LNS_SUB   = 3'd6,
    LNS_COPY  = 3'd7
  } lns_op_e;

  // Correction entry for one table slot, evaluated at the slot centre.
  // is_sub selects log2(1 - 2^-z) instead of log2(1 + 2^-z).
  function automatic int corr_entry(input int idx, input bit is_sub,
                                    input int steps, input int frac_bits);
    real zq;
    real t;
    real f;
    zq = (real'(idx) + 0.5) / real'(steps);
    t  = $pow(2.0, -zq);
    f  = is_sub ? (1.0 - t) : (1.0 + t);
    f  = $ln(f) / $ln(2.0) * real'(1 << frac_bits);
    if (f >= 0.0) return $rtoi(f + 0.5);
    return -$rtoi(0.5 - f);
  endfunction

endpackage

// File: rtl/lns_prep.sv
module lns_prep #(
  parameter int LOG_W   = 15,
  parameter int QSH     = 5,
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8
) (
  input  logic signed [LOG_W-1:0] a_log,
  input  logic signed [LOG_W-1:0] b_log,
  input  logic                    a_s,
  input  logic                    b_s,
  input  logic                    op_sub,
  output logic                    a_bigger,
  output logic                    eff_sub,
  output logic                    z_zero,
  output logic                    in_range,
  output logic [IDX_W-1:0]        idx
);
  logic signed [LOG_W:0] diff;
  logic        [LOG_W:0] mag;
  logic        [LOG_W:0] slot;

  assign diff     = {a_log[LOG_W-1], a_log} - {b_log[LOG_W-1], b_log};
  assign mag      = diff[LOG_W] ? $unsigned(-diff) : $unsigned(diff);
  assign slot     = mag >> QSH;
  assign in_range = slot < (LOG_W+1)'(ENTRIES);
  assign idx      = slot[IDX_W-1:0];
  assign a_bigger = !diff[LOG_W];
  assign eff_sub  = a_s ^ b_s ^ op_sub;
  assign z_zero   = (mag == '0);
endmodule

// File: rtl/lns_corr_rom.sv
module lns_corr_rom #(
  parameter int LOG_W     = 15,
  parameter int FRAC_BITS = 9,
  parameter int QSH       = 5,
  parameter int ENTRIES   = 256,
  parameter int IDX_W     = 8
) (
  input  logic [IDX_W-1:0]        idx,
  input  logic                    is_sub,
  output logic signed [LOG_W-1:0] corr
);
  localparam int STEPS = 1 << (FRAC_BITS - QSH);

  logic signed [LOG_W-1:0] sum_tab  [ENTRIES];
  logic signed [LOG_W-1:0] diff_tab [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    localparam int SUMV  = lns_pkg::corr_entry(i, 1'b0, STEPS, FRAC_BITS);
    localparam int DIFFV = lns_pkg::corr_entry(i, 1'b1, STEPS, FRAC_BITS);
    assign sum_tab[i]  = LOG_W'(SUMV);
    assign diff_tab[i] = LOG_W'(DIFFV);
  end

  assign corr = is_sub ? diff_tab[idx] : sum_tab[idx];
endmodule

// File: rtl/lns_finish.sv
module lns_finish
  import lns_pkg::*;
#(
  parameter int LOG_W = 15
) (
  input  lns_op_e                 op,
  input  logic                    a_zero,
  input  logic                    a_s,
  input  logic signed [LOG_W-1:0] a_log,
  input  logic                    b_zero,
  input  logic                    b_s,
  input  logic signed [LOG_W-1:0] b_log,
  input  logic                    a_bigger,
  input  logic                    eff_sub,
  input  logic                    z_zero,
  input  logic                    in_range,
  input  logic signed [LOG_W-1:0] corr,
  output logic                    res_zero,
  output logic                    res_s,
  output logic [LOG_W-1:0]        res_log,
  output logic                    res_ovf
);
  localparam int EW    = LOG_W + 3;
  localparam int MAX_I = (1 << (LOG_W-1)) - 1;
  localparam int MIN_I = -(1 << (LOG_W-1));
  localparam logic signed [EW-1:0] MAXV = EW'(MAX_I);
  localparam logic signed [EW-1:0] MINV = EW'(MIN_I);

  logic signed [EW-1:0] aw, bw, cw, raw;
  logic zero_r, sign_r, force_ovf, b_eff;

  assign aw    = EW'(a_log);
  assign bw    = EW'(b_log);
  assign cw    = in_range ? EW'(corr) : '0;
  assign b_eff = b_s ^ (op == LNS_SUB);

  always_comb begin
    zero_r    = 1'b0;
    sign_r    = 1'b0;
    force_ovf = 1'b0;
    raw       = '0;
    case (op)
      LNS_MUL: begin
        zero_r = a_zero | b_zero;
        sign_r = a_s ^ b_s;
        raw    = aw + bw;
      end
      LNS_DIV: begin
        sign_r = a_s ^ b_s;
        if (b_zero)      force_ovf = 1'b1;
        else if (a_zero) zero_r    = 1'b1;
        else             raw       = aw - bw;
      end
      LNS_SQR: begin
        zero_r = a_zero;
        raw    = aw <<< 1;
      end
      LNS_CUBE: begin
        zero_r = a_zero;
        sign_r = a_s;
        raw    = (aw <<< 1) + aw;
      end
      LNS_RECIP: begin
        sign_r = a_s;
        if (a_zero) force_ovf = 1'b1;
        else        raw       = -aw;
      end
      LNS_ADD, LNS_SUB: begin
        if (a_zero && b_zero) begin
          zero_r = 1'b1;
        end else if (a_zero) begin
          sign_r = b_eff;
          raw    = bw;
        end else if (b_zero) begin
          sign_r = a_s;
          raw    = aw;
        end else if (eff_sub && z_zero) begin
          zero_r = 1'b1;
        end else begin
          sign_r = a_bigger ? a_s : b_eff;
          raw    = (a_bigger ? aw : bw) + cw;
        end
      end
      LNS_COPY: begin
        zero_r = a_zero;
        sign_r = a_s;
        raw    = aw;
      end
    endcase
  end

  always_comb begin
    res_zero = zero_r;
    res_s    = sign_r;
    res_ovf  = 1'b0;
    res_log  = raw[LOG_W-1:0];
    if (zero_r) begin
      res_s   = 1'b0;
      res_log = '0;
    end else if (force_ovf || raw > MAXV) begin
      res_ovf = 1'b1;
      res_log = MAXV[LOG_W-1:0];
    end else if (raw < MINV) begin
      res_ovf = 1'b1;
      res_log = MINV[LOG_W-1:0];
    end
  end
endmodule

// File: rtl/lns_arith_unit.sv
module lns_arith_unit
  import lns_pkg::*;
#(
  parameter int INT_BITS  = 6,
  parameter int FRAC_BITS = 9,
  parameter int QSH       = 5,
  parameter int Z_SPAN    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [2:0]                    in_op,
  input  logic                          in_a_zero,
  input  logic [INT_BITS+FRAC_BITS:0]   in_a,
  input  logic                          in_b_zero,
  input  logic [INT_BITS+FRAC_BITS:0]   in_b,
  output logic                          out_valid,
  output logic                          out_zero,
  output logic                          out_ovf,
  output logic [INT_BITS+FRAC_BITS:0]   out_val
);
  localparam int LOG_W   = INT_BITS + FRAC_BITS;
  localparam int ENTRIES = Z_SPAN << (FRAC_BITS - QSH);
  localparam int IDX_W   = $clog2(ENTRIES);

  // Named event for the checker: an operation enters the pipe.
  logic accept;
  assign accept = in_valid & in_ready;

  logic signed [LOG_W-1:0] a_log_in, b_log_in;
  assign a_log_in = in_a[LOG_W-1:0];
  assign b_log_in = in_b[LOG_W-1:0];

  logic p_a_bigger, p_eff_sub, p_z_zero, p_in_range;
  logic [IDX_W-1:0] p_idx;

  lns_prep #(.LOG_W(LOG_W), .QSH(QSH), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) prep_i (
    .a_log(a_log_in), .b_log(b_log_in), .a_s(in_a[LOG_W]), .b_s(in_b[LOG_W]),
    .op_sub(in_op == LNS_SUB), .a_bigger(p_a_bigger), .eff_sub(p_eff_sub),
    .z_zero(p_z_zero), .in_range(p_in_range), .idx(p_idx)
  );

  // Stage 1 registers
  logic                    s1_valid;
  lns_op_e                 s1_op;
  logic                    s1_a_zero, s1_a_s, s1_b_zero, s1_b_s;
  logic signed [LOG_W-1:0] s1_a_log, s1_b_log;
  logic                    s1_a_bigger, s1_eff_sub, s1_z_zero, s1_in_range;
  logic [IDX_W-1:0]        s1_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ready <= 1'b0;
      s1_valid <= 1'b0;
    end else begin
      in_ready <= 1'b1;
      s1_valid <= accept;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_op       <= lns_op_e'(in_op);
      s1_a_zero   <= in_a_zero;
      s1_a_s      <= in_a[LOG_W];
      s1_a_log    <= a_log_in;
      s1_b_zero   <= in_b_zero;
      s1_b_s      <= in_b[LOG_W];
      s1_b_log    <= b_log_in;
      s1_a_bigger <= p_a_bigger;
      s1_eff_sub  <= p_eff_sub;
      s1_z_zero   <= p_z_zero;
      s1_in_range <= p_in_range;
      s1_idx      <= p_idx;
    end
  end

  logic signed [LOG_W-1:0] corr;

  lns_corr_rom #(.LOG_W(LOG_W), .FRAC_BITS(FRAC_BITS), .QSH(QSH),
                 .ENTRIES(ENTRIES), .IDX_W(IDX_W)) rom_i (
    .idx(s1_idx), .is_sub(s1_eff_sub), .corr(corr)
  );

  logic             f_zero, f_s, f_ovf;
  logic [LOG_W-1:0] f_log;

  lns_finish #(.LOG_W(LOG_W)) finish_i (
    .op(s1_op), .a_zero(s1_a_zero), .a_s(s1_a_s), .a_log(s1_a_log),
    .b_zero(s1_b_zero), .b_s(s1_b_s), .b_log(s1_b_log),
    .a_bigger(s1_a_bigger), .eff_sub(s1_eff_sub), .z_zero(s1_z_zero),
    .in_range(s1_in_range), .corr(corr),
    .res_zero(f_zero), .res_s(f_s), .res_log(f_log), .res_ovf(f_ovf)
  );

  // Stage 2 (output) registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_zero  <= 1'b0;
      out_ovf   <= 1'b0;
      out_val   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_zero <= f_zero;
        out_ovf  <= f_ovf;
        out_val  <= {f_s, f_log};
      end
    end
  end
endmodule

// File: rtl/lns_arith_unit_chk.sv
module lns_arith_unit_chk #(
  parameter int LOG_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_zero,
  input logic             out_ovf,
  input logic [LOG_W:0]   out_val
);
  localparam logic [LOG_W-1:0] MAXP = {1'b0, {(LOG_W-1){1'b1}}};
  localparam logic [LOG_W-1:0] MINP = {1'b1, {(LOG_W-1){1'b0}}};

  AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(accept, 2)); // R11

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready); // R11

  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_val == '0 && !out_ovf)); // R1

  AST_OVF_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_val[LOG_W-1:0] == MAXP || out_val[LOG_W-1:0] == MINP)); // R10
endmodule

bind lns_arith_unit lns_arith_unit_chk #(.LOG_W(LOG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .accept(accept), .in_ready(in_ready),
  .out_valid(out_valid), .out_zero(out_zero), .out_ovf(out_ovf), .out_val(out_val)
);

// File: tb/lns_arith_unit_tb_top.sv
`timescale 1ns/1ps
module lns_arith_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_op = '0;
  logic in_a_zero = 1'b0, in_b_zero = 1'b0;
  logic [15:0] in_a = '0, in_b = '0;
  logic out_valid, out_zero, out_ovf;
  logic [15:0] out_val;

  always #2.5 clk = ~clk;

  lns_arith_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a_zero(in_a_zero), .in_a(in_a),
    .in_b_zero(in_b_zero), .in_b(in_b),
    .out_valid(out_valid), .out_zero(out_zero), .out_ovf(out_ovf), .out_val(out_val)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles, expected under 150000", cyc);
      summary();
      $finish;
    end
  end

  // Table value from R7, computed from the defining formula
  function automatic int ref_corr(int z, bit sub);
    real zq, t, r;
    int slot;
    slot = z / 32;
    if (slot >= 256) return 0;
    zq = (real'(slot) + 0.5) / 16.0;
    t = $pow(2.0, -zq);
    r = $ln(sub ? (1.0 - t) : (1.0 + t)) / $ln(2.0) * 512.0;
    if (r >= 0.0) return int'($floor(r + 0.5));
    return -int'($floor(0.5 - r));
  endfunction

  task automatic predict(input int op, input bit az, input bit as, input int al,
                         input bit bz, input bit bs, input int bl,
                         output bit ez, output bit eo, output bit es, output int el);
    int raw, d, z;
    bit bse, sub, big_ovf;
    ez = 0; eo = 0; es = 0; raw = 0; big_ovf = 0;
    case (op)
      0: begin es = as ^ bs; if (az || bz) ez = 1; else raw = al + bl; end
      1: begin es = as ^ bs; if (bz) big_ovf = 1; else if (az) ez = 1; else raw = al - bl; end
      2: begin if (az) ez = 1; else raw = 2 * al; end
      3: begin es = as; if (az) ez = 1; else raw = 3 * al; end
      4: begin es = as; if (az) big_ovf = 1; else raw = 0 - al; end
      5, 6: begin
        bse = bs ^ (op == 6);
        if (az && bz) ez = 1;
        else if (az) begin es = bse; raw = bl; end
        else if (bz) begin es = as; raw = al; end
        else begin
          d = al - bl;
          z = (d < 0) ? -d : d;
          sub = (as != bse);
          if (sub && z == 0) ez = 1;
          else begin
            es  = (d >= 0) ? as : bse;
            raw = ((d >= 0) ? al : bl) + ref_corr(z, sub);
          end
        end
      end
      default: begin es = as; if (az) ez = 1; else raw = al; end
    endcase
    el = raw;
    if (ez) begin es = 0; el = 0; end
    else if (big_ovf || raw > 16383) begin eo = 1; el = 16383; end
    else if (raw < -16384) begin eo = 1; el = -16384; end
  endtask

  task automatic drive(input int op, input bit az, input bit as, input int al,
                       input bit bz, input bit bs, input int bl);
    in_op = 3'(op);
    in_a_zero = az; in_a = {as, al[14:0]};
    in_b_zero = bz; in_b = {bs, bl[14:0]};
  endtask

  task automatic check(input string tag, input bit ez, input bit eo, input bit es, input int el);
    logic [15:0] ev;
    ev = ez ? 16'h0 : {es, el[14:0]};
    n_chk++;
    if (out_valid !== 1'b1 || out_zero !== ez || out_ovf !== eo || out_val !== ev) begin
      n_fail++;
      $display("FAIL %s: got v=%b z=%b o=%b val=%h, expected v=1 z=%b o=%b val=%h",
               tag, out_valid, out_zero, out_ovf, out_val, ez, eo, ev);
    end
  endtask

  task automatic run_one(input string tag, input int op, input bit az, input bit as, input int al,
                         input bit bz, input bit bs, input int bl);
    bit ez, eo, es;
    int el;
    @(negedge clk);
    drive(op, az, as, al, bz, bs, bl);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    predict(op, az, as, al, bz, bs, bl, ez, eo, es, el);
    check(tag, ez, eo, es, el);
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b, expected %b", tag, got, exp);
    end
  endtask

  initial begin
    // R11: reset state
    repeat (4) @(negedge clk);
    check_bit("R11 out_valid in reset", out_valid, 1'b0);
    check_bit("R11 in_ready in reset", in_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R11 in_ready after reset", in_ready, 1'b1);
    check_bit("R11 out_valid idle", out_valid, 1'b0);

    // R2 R3: multiply and divide sweep
    for (int ai = -16384; ai <= 16383; ai += 1499)
      for (int bi = -16384; bi <= 16383; bi += 1601) begin
        run_one("R2 mul", 0, 1'b0, ai[0], ai, 1'b0, bi[1], bi);
        run_one("R3 div", 1, 1'b0, ai[1], ai, 1'b0, bi[0], bi);
      end

    // R4 R5 R12: unary sweep
    for (int ai = -16384; ai <= 16383; ai += 97) begin
      run_one("R4 square", 2, 1'b0, ai[0], ai, 1'b0, 1'b0, 0);
      run_one("R4 cube",   3, 1'b0, ai[0], ai, 1'b0, 1'b0, 0);
      run_one("R5 recip",  4, 1'b0, ai[1], ai, 1'b0, 1'b0, 0);
      run_one("R12 copy",  7, 1'b0, ai[1], ai, 1'b0, 1'b0, 0);
    end

    // R6 R7: add/subtract sweep across the whole table span and beyond
    for (int d = 0; d <= 8400; d += 7) begin
      int al, bl;
      al = (d % 3 == 0) ? 1000 - d : 1000;
      bl = (d % 3 == 0) ? 1000 : 1000 - d;
      run_one("R6 R7 add", 5, 1'b0, d[3], al, 1'b0, d[4], bl);
      run_one("R6 R7 sub", 6, 1'b0, d[4], al, 1'b0, d[5], bl);
    end
    run_one("R7 beyond span", 5, 1'b0, 1'b0, 9000, 1'b0, 1'b0, 9000 - 8192);
    run_one("R7 last slot",   5, 1'b0, 1'b0, 9000, 1'b0, 1'b0, 9000 - 8191);

    // R8: cancellation
    run_one("R8 sub equal",        6, 1'b0, 1'b0, 700, 1'b0, 1'b0, 700);
    run_one("R8 add opposite",     5, 1'b0, 1'b1, -300, 1'b0, 1'b0, -300);
    run_one("R6 add equal same",   5, 1'b0, 1'b1, -300, 1'b0, 1'b1, -300);

    // R1 R2 R3 R4 R5 R9 R12: zero operands
    run_one("R2 mul a zero",   0, 1'b1, 1'b1, 123, 1'b0, 1'b0, 456);
    run_one("R2 mul b zero",   0, 1'b0, 1'b0, 123, 1'b1, 1'b1, 456);
    run_one("R3 div by zero",  1, 1'b0, 1'b1, 50, 1'b1, 1'b0, 60);
    run_one("R3 zero dividend",1, 1'b1, 1'b0, 50, 1'b0, 1'b1, 60);
    run_one("R3 zero by zero", 1, 1'b1, 1'b0, 50, 1'b1, 1'b1, 60);
    run_one("R4 square zero",  2, 1'b1, 1'b1, 77, 1'b0, 1'b0, 0);
    run_one("R4 cube zero",    3, 1'b1, 1'b1, 77, 1'b0, 1'b0, 0);
    run_one("R5 recip zero",   4, 1'b1, 1'b1, 77, 1'b0, 1'b0, 0);
    run_one("R9 add a zero",   5, 1'b1, 1'b0, 10, 1'b0, 1'b1, -2000);
    run_one("R9 sub a zero",   6, 1'b1, 1'b0, 10, 1'b0, 1'b0, -2000);
    run_one("R9 sub b zero",   6, 1'b0, 1'b1, 4321, 1'b1, 1'b0, 9);
    run_one("R9 both zero",    5, 1'b1, 1'b1, 4321, 1'b1, 1'b0, 9);
    run_one("R12 copy zero",   7, 1'b1, 1'b1, 4321, 1'b0, 1'b0, 0);

    // R10: saturation corners
    run_one("R10 mul high",   0, 1'b0, 1'b0, 16383, 1'b0, 1'b0, 1);
    run_one("R10 mul low",    0, 1'b0, 1'b0, -16384, 1'b0, 1'b1, -1);
    run_one("R10 cube high",  3, 1'b0, 1'b1, 6000, 1'b0, 1'b0, 0);
    run_one("R10 square low", 2, 1'b0, 1'b1, -9000, 1'b0, 1'b0, 0);
    run_one("R10 recip min",  4, 1'b0, 1'b0, -16384, 1'b0, 1'b0, 0);
    run_one("R10 add high",   5, 1'b0, 1'b0, 16383, 1'b0, 1'b0, 16383);
    run_one("R10 sub low",    6, 1'b0, 1'b0, -16384, 1'b0, 1'b0, -16383);

    // R11: back-to-back stream
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        bit ez, eo, es;
        int el;
        predict(0, 1'b0, k[0], (k-2)*500 - 2000, 1'b0, 1'b1, 300, ez, eo, es, el);
        if (k - 2 != 0) predict(0, 1'b0, (k-2) % 2 == 1, (k-2)*500 - 2000, 1'b0, 1'b1, 300, ez, eo, es, el);
        else predict(0, 1'b0, 1'b0, -2000, 1'b0, 1'b1, 300, ez, eo, es, el);
        check("R11 stream", ez, eo, es, el);
      end
      if (k < 8) begin
        drive(0, 1'b0, k[0], k*500 - 2000, 1'b0, 1'b1, 300);
        in_valid = 1'b1;
      end else in_valid = 1'b0;
    end
    @(negedge clk);
    check_bit("R11 valid drops after stream", out_valid, 1'b0);

    summary();
    $finish;
  end
endmodule